// File: doc/BRIEF.md
# TLB Translation-Word Entry Array

This block holds the translation half of every entry in a unified translation look-aside buffer. Each entry carries a physical page number and a set of page attributes. Software reaches it through a special-register port with a normal access and an extended access. The entry is chosen by a separate index value that the surrounding logic keeps up to date. Address translation, permission checks, exceptions and zone protection are handled elsewhere. This block only stores entries, applies the fixed-bit rules and returns read data.

The physical address width can exceed the 32-bit data path. In that case each entry is wider than one data word. The upper bits are written first, through an extended write, and are held in a staging register. A normal write of the low word then commits the whole entry in a single clock edge. On a 64-bit data path a normal access reads or writes the whole entry at once. A configuration switch can block software reads. All entries are zero when the configuration loads. The functional reset leaves the array contents unchanged.

Top module: `tlb_lo_array`

## Requirements
- R1: Every access uses the entry selected by `tlb_index` in that cycle. Read data appears on `rd_data` on the clock edge that samples the read strobe. It then stays unchanged until the next read or reset.
- R2: The entry layout, from least significant bit up, is: guarded (bit 0), coherent (bit 1), cache inhibit (bit 2), write-through (bit 3), zone select (bits 7:4), writable (bit 8), executable (bit 9). The page number occupies bit 10 and upward. Writable bits read back as written.
- R3: The coherent bit (bit 1) always reads 0. Writing 1 to it has no effect.
- R4: With `WRITEBACK`=1, the write-through bit is read/write and starts at 0. With `WRITEBACK`=0, it always reads 1, whatever value is written.
- R5: In extended mode (`DATA_W`=32 and `PADDR_W`>32), `wr_hi` places `wr_data[PADDR_W-33:0]` in a staging register and leaves the array unchanged. The next `wr_lo` writes {staged bits, `wr_data[31:0]`} to the indexed entry in one clock edge and empties the staging register.
- R6: In extended mode, a `wr_lo` issued while nothing is staged keeps the entry's existing upper bits.
- R7: In extended mode, `rd_lo` returns entry bits 31:0. `rd_hi` returns the upper `PADDR_W-32` bits, zero-extended. When `rd_lo` and `rd_hi` are asserted together, the low word is returned.
- R8: With `DATA_W`=64, a single `wr_lo` writes the whole entry and a single `rd_lo` returns the whole entry. `wr_hi` has no effect, and `rd_hi` returns 0.
- R9: All entries read 0 after configuration load, apart from the fixed bit in R4. The functional reset clears `rd_data` and the staging register but does not clear the array.
- R10: With `READ_EN`=0, every read returns all zeros and changes nothing else.
- R11: When a read and a write hit the same entry in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low functional reset; does not touch the array |
| tlb_index | input | $clog2(ENTRIES) | Entry selected for the current access |
| wr_lo | input | 1 | Normal write strobe (low word, or whole entry on a 64-bit path) |
| wr_hi | input | 1 | Extended write strobe (upper page-number bits) |
| wr_data | input | DATA_W | Write data |
| rd_lo | input | 1 | Normal read strobe |
| rd_hi | input | 1 | Extended read strobe |
| rd_data | output | DATA_W | Registered read data |

## Verification
A stale or missing staging state shows up on the first extended read after a low-word write. The upper page bits are then either the previous upper bits or bits that were never committed. This appears two accesses after the faulty write. A fixed-bit error shows on the very next normal read, as a 1 in the coherent position or a 0 in the write-through position. A reset that wrongly clears the array is exposed by the first read after reset, which returns zeros where older contents should remain. A wrong read-before-write order shows in the read data of the colliding cycle itself.

// File: rtl/tlb_lo_pkg.sv
// Package: shared field positions and the fixed-bit rule for TLB
// translation-word entries. Assumes the attribute field is the low ten bits.
package tlb_lo_pkg;
    localparam int ATTR_W = 10;
    localparam int LO_W   = 32;
    localparam int POS_G  = 0;
    localparam int POS_M  = 1;
    localparam int POS_I  = 2;
    localparam int POS_W  = 3;
    localparam int POS_Z  = 4;
    localparam int POS_WR = 8;
    localparam int POS_EX = 9;

    // Applies the fixed-bit rules to a raw attribute field.
    function automatic logic [ATTR_W-1:0] fix_attr(input logic [ATTR_W-1:0] raw,
                                                   input bit wb_cfg);
        logic [ATTR_W-1:0] r;
        r        = raw;
        r[POS_M] = 1'b0;
        if (!wb_cfg) r[POS_W] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/tlb_lo_stage.sv
// Staging register for the upper page-number bits of a wide entry.
// Assumes that a load and a commit in the same cycle keep the new value staged.
module tlb_lo_stage #(
    parameter int HI_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            commit,
    input  logic [HI_W-1:0] din,
    output logic            valid,
    output logic [HI_W-1:0] q
);
    // Captures the upper bits and tracks whether they are still pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            q     <= '0;
        end else if (load) begin
            valid <= 1'b1;
            q     <= din;
        end else if (commit) begin
            valid <= 1'b0;
        end
    end

    // R5
    stage_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> valid);
    // R5
    stage_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !load) |=> !valid);
endmodule

// File: rtl/tlb_lo_store.sv
// Entry storage: synchronous write, combinational read at the index.
// It has no reset, so contents survive a functional reset. The initial value
// models the state after configuration load.
module tlb_lo_store #(
    parameter int               ENTRIES = 64,
    parameter int               IDX_W   = 6,
    parameter int               ENT_W   = 48,
    parameter logic [ENT_W-1:0] INIT    = '0
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [ENT_W-1:0] wentry,
    output logic [ENT_W-1:0] rentry
);
    logic [ENT_W-1:0] mem [ENTRIES];

    // Configuration-load contents.
    initial begin
        for (int i = 0; i < ENTRIES; i++) mem[i] = INIT;
    end

    // Writes the sanitised entry at the current index.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wentry;
    end

    assign rentry = mem[idx];
endmodule

// File: rtl/tlb_lo_rdport.sv
// Read formatter: selects the low or high view of an entry and registers it.
// Assumes the views are zero-extended to the data path and that a blocked
// read returns zeros.
module tlb_lo_rdport #(
    parameter int DATA_W  = 32,
    parameter int ENT_W   = 48,
    parameter bit EXT     = 1'b1,
    parameter bit READ_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic [ENT_W-1:0]  entry,
    output logic [DATA_W-1:0] rdata
);
    import tlb_lo_pkg::*;

    logic [DATA_W-1:0] lo_view;
    logic [DATA_W-1:0] hi_view;

    if (EXT) begin : g_split
        // Wide entry: the low word and the upper bits are read separately.
        always_comb begin
            lo_view = DATA_W'(entry[LO_W-1:0]);
            hi_view = DATA_W'(entry[ENT_W-1:LO_W]);
        end
    end else begin : g_whole
        // Entry fits the data path: one normal read returns all of it.
        always_comb begin
            lo_view = DATA_W'(entry);
            hi_view = '0;
        end
    end

    // Registers the selected view; the low view takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_lo) rdata <= READ_EN ? lo_view : '0;
        else if (rd_hi) rdata <= READ_EN ? hi_view : '0;
    end

    // R1
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_lo && !rd_hi) |=> $stable(rdata));

    if (!READ_EN) begin : g_blk
        // R10
        rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_lo || rd_hi) |=> (rdata == '0));
    end
endmodule

// File: rtl/tlb_lo_array.sv
// Top: translation-word storage for a unified TLB, with a staged two-part
// write for wide entries. Assumes tlb_index is stable for the cycle of each
// access and that software writes the upper bits before the low word.
module tlb_lo_array #(
    parameter int ENTRIES   = 64,
    parameter int DATA_W    = 32,
    parameter int PADDR_W   = 48,
    parameter bit WRITEBACK = 1'b1,
    parameter bit READ_EN   = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(ENTRIES)-1:0] tlb_index,
    input  logic                       wr_lo,
    input  logic                       wr_hi,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_lo,
    input  logic                       rd_hi,
    output logic [DATA_W-1:0]          rd_data
);
    import tlb_lo_pkg::*;

    localparam int   IDX_W = $clog2(ENTRIES);
    localparam int   ENT_W = PADDR_W;
    localparam bit   EXT   = (DATA_W == 32) && (PADDR_W > 32);
    localparam int   HI_W  = EXT ? PADDR_W - LO_W : 1;
    localparam logic [ENT_W-1:0] INIT_ENT =
        WRITEBACK ? '0 : (ENT_W'(1) << POS_W);

    logic [ENT_W-1:0] cur_entry;
    logic [ENT_W-1:0] raw_entry;
    logic [ENT_W-1:0] new_entry;
    logic             stg_valid;
    logic [HI_W-1:0]  stg_q;
    logic             stg_load;

    assign stg_load = EXT ? wr_hi : 1'b0;

    tlb_lo_stage #(.HI_W(HI_W)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (stg_load),
        .commit (wr_lo),
        .din    (wr_data[HI_W-1:0]),
        .valid  (stg_valid),
        .q      (stg_q)
    );

    if (EXT) begin : g_wide
        // Merges the staged or existing upper bits with the new low word.
        always_comb begin
            raw_entry = {stg_valid ? stg_q : cur_entry[ENT_W-1:LO_W],
                         wr_data[LO_W-1:0]};
        end
    end else begin : g_narrow
        // Takes the whole entry from one data word.
        always_comb begin
            raw_entry = wr_data[ENT_W-1:0];
        end
    end

    // Applies the fixed attribute bits before storage.
    always_comb begin
        new_entry = {raw_entry[ENT_W-1:ATTR_W],
                     fix_attr(raw_entry[ATTR_W-1:0], WRITEBACK)};
    end

    tlb_lo_store #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .ENT_W   (ENT_W),
        .INIT    (INIT_ENT)
    ) u_store (
        .clk    (clk),
        .we     (wr_lo),
        .idx    (tlb_index),
        .wentry (new_entry),
        .rentry (cur_entry)
    );

    tlb_lo_rdport #(
        .DATA_W  (DATA_W),
        .ENT_W   (ENT_W),
        .EXT     (EXT),
        .READ_EN (READ_EN)
    ) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_lo (rd_lo),
        .rd_hi (rd_hi),
        .entry (cur_entry),
        .rdata (rd_data)
    );

    // R3
    coh_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> !rd_data[POS_M]);

    if (!WRITEBACK && READ_EN) begin : g_wt
        // R4
        wt_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_lo |=> rd_data[POS_W]);
    end

    if (EXT) begin : g_hi_chk
        // R7
        hi_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hi && !rd_lo) |=> (rd_data[DATA_W-1:HI_W] == '0));
    end
endmodule

// File: tb/tlb_lo_array_tb.sv
// Directed bench: four configurations share one stimulus stream.
module tlb_lo_array_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  idx = '0;
    logic        wl = 1'b0, wh = 1'b0, rl = 1'b0, rh = 1'b0;
    logic [63:0] wd = '0;
    logic [31:0] rd_a, rd_b, rd_c;
    logic [63:0] rd_d;
    int          nvec = 0;
    int          nfail = 0;

    always #10 clk = ~clk;

    // Extended mode, write-back, readable.
    tlb_lo_array #(.DATA_W(32), .PADDR_W(48), .WRITEBACK(1'b1), .READ_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .tlb_index(idx), .wr_lo(wl), .wr_hi(wh),
        .wr_data(wd[31:0]), .rd_lo(rl), .rd_hi(rh), .rd_data(rd_a));
    // Narrow, write-through fixed.
    tlb_lo_array #(.DATA_W(32), .PADDR_W(32), .WRITEBACK(1'b0), .READ_EN(1'b1)) u_nowb (
        .clk(clk), .rst_n(rst_n), .tlb_index(idx), .wr_lo(wl), .wr_hi(wh),
        .wr_data(wd[31:0]), .rd_lo(rl), .rd_hi(rh), .rd_data(rd_b));
    // Reads blocked.
    tlb_lo_array #(.DATA_W(32), .PADDR_W(32), .WRITEBACK(1'b1), .READ_EN(1'b0)) u_nord (
        .clk(clk), .rst_n(rst_n), .tlb_index(idx), .wr_lo(wl), .wr_hi(wh),
        .wr_data(wd[31:0]), .rd_lo(rl), .rd_hi(rh), .rd_data(rd_c));
    // 64-bit data path.
    tlb_lo_array #(.DATA_W(64), .PADDR_W(64), .WRITEBACK(1'b1), .READ_EN(1'b1)) u_d64 (
        .clk(clk), .rst_n(rst_n), .tlb_index(idx), .wr_lo(wl), .wr_hi(wh),
        .wr_data(wd), .rd_lo(rl), .rd_hi(rh), .rd_data(rd_d));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic op(input int i, input bit w_l, input bit w_h, input bit r_l,
                      input bit r_h, input logic [63:0] d);
        @(negedge clk);
        idx = 6'(i); wl = w_l; wh = w_h; rl = r_l; rh = r_h; wd = d;
        @(negedge clk);
        wl = 1'b0; wh = 1'b0; rl = 1'b0; rh = 1'b0;
    endtask

    task automatic t_reset_state;
        op(0, 0, 0, 1, 0, 0);
        chk("R9 dut init", 64'(rd_a), 64'h0);
        chk("R4 nowb init W=1", 64'(rd_b), 64'h8);
        chk("R10 nord init", 64'(rd_c), 64'h0);
        chk("R9 d64 init", rd_d, 64'h0);
        op(0, 0, 0, 0, 1, 0);
        chk("R9 dut init hi", 64'(rd_a), 64'h0);
    endtask

    task automatic t_fields;
        op(5, 1, 0, 0, 0, 64'h1234_5670);
        op(5, 0, 0, 1, 0, 0);
        chk("R2 layout readback", 64'(rd_a), 64'h1234_5670);
        chk("R4 nowb W forced", 64'(rd_b), 64'h1234_5678);
        op(6, 1, 0, 0, 0, 64'hFFFF_FFFF);
        op(6, 0, 0, 1, 0, 0);
        chk("R3 coherent bit zero", 64'(rd_a), 64'hFFFF_FFFD);
        chk("R3 nowb coherent zero", 64'(rd_b), 64'hFFFF_FFFD);
        op(6, 1, 0, 0, 0, 64'h0);
        op(6, 0, 0, 1, 0, 0);
        chk("R4 W writable to 0", 64'(rd_a), 64'h0);
        chk("R4 nowb W stays 1", 64'(rd_b), 64'h8);
    endtask

    task automatic t_wide_path;
        op(7, 1, 0, 0, 0, 64'hA5A5_0000_1234_5678);
        op(7, 0, 0, 1, 0, 0);
        chk("R8 full entry read", rd_d, 64'hA5A5_0000_1234_5678);
        op(7, 0, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        op(7, 0, 0, 1, 0, 0);
        chk("R8 ext write ignored", rd_d, 64'hA5A5_0000_1234_5678);
        op(7, 0, 0, 0, 1, 0);
        chk("R8 ext read zero", rd_d, 64'h0);
    endtask

    task automatic t_ext_commit;
        // u_dut still holds 0xFFFF staged from t_wide_path.
        op(10, 1, 0, 0, 0, 64'h1111_0000);
        op(10, 0, 0, 0, 1, 0);
        chk("R5 staged bits committed", 64'(rd_a), 64'hFFFF);
        op(10, 0, 1, 0, 0, 64'hBEEF);
        op(10, 0, 0, 0, 1, 0);
        chk("R5 no change before commit", 64'(rd_a), 64'hFFFF);
        op(10, 1, 0, 0, 0, 64'h2222_3330);
        op(10, 0, 0, 0, 1, 0);
        chk("R7 upper read", 64'(rd_a), 64'hBEEF);
        op(10, 0, 0, 1, 0, 0);
        chk("R7 low read", 64'(rd_a), 64'h2222_3330);
    endtask

    task automatic t_keep_upper;
        op(10, 1, 0, 0, 0, 64'h3333_0000);
        op(10, 0, 0, 0, 1, 0);
        chk("R6 upper kept", 64'(rd_a), 64'hBEEF);
        op(10, 0, 0, 1, 0, 0);
        chk("R6 low updated", 64'(rd_a), 64'h3333_0000);
    endtask

    task automatic t_index_order;
        op(5, 0, 0, 1, 0, 0);
        chk("R1 index select", 64'(rd_a), 64'h1234_5670);
        repeat (3) @(negedge clk);
        chk("R1 data held", 64'(rd_a), 64'h1234_5670);
        op(10, 1, 0, 1, 0, 64'h4444_0000);
        chk("R11 read old value", 64'(rd_a), 64'h3333_0000);
        op(10, 0, 0, 1, 0, 0);
        chk("R11 new value after", 64'(rd_a), 64'h4444_0000);
        op(10, 0, 0, 1, 1, 0);
        chk("R7 low priority", 64'(rd_a), 64'h4444_0000);
    endtask

    task automatic t_func_reset;
        op(10, 0, 1, 0, 0, 64'h7777);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 rdata cleared", 64'(rd_a), 64'h0);
        rst_n = 1'b1;
        op(10, 1, 0, 0, 0, 64'h5555_0000);
        op(10, 0, 0, 0, 1, 0);
        chk("R9 stage cleared, array kept", 64'(rd_a), 64'hBEEF);
        op(5, 0, 0, 1, 0, 0);
        chk("R9 other entry kept", 64'(rd_a), 64'h1234_5670);
    endtask

    task automatic t_read_block;
        op(5, 0, 0, 1, 0, 0);
        chk("R10 blocked low read", 64'(rd_c), 64'h0);
        op(10, 0, 0, 0, 1, 0);
        chk("R10 blocked high read", 64'(rd_c), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_fields();
        t_wide_path();
        t_ext_commit();
        t_keep_upper();
        t_index_order();
        t_func_reset();
        t_read_block();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule